// File: doc/BRIEF.md
# Angle Readout Latch with Encoder Emulation

This block takes the word from a tracking angle counter and presents it to a host in two halves, each with its own output-enable line for an external three-state driver. A holding register follows the counter while the host leaves the freeze input high. It refreshes only on clocks that fall outside a counter-busy strobe, so a count that is part-way through a change is never captured. Pulling the freeze input low holds the presented word steady for a read. The counter keeps tracking underneath. Bits below the selected resolution always read as zero.

In encoder mode, the low-order bits of the live counter are turned into quadrature channels A and B. The busy output then carries a zero-position index pulse, and the lower half of the bus is enabled all the time. The host uses the two enable inputs to read the upper half and the lower half. Each output enable follows its input after a fixed number of clocks, and releases after the same number of clocks.

Top module: `angle_readout_port`

## Requirements
- R1: While rst_n is low at a clock edge, every output is driven to 0 on that edge, including data_o, both output enables, the quadrature outputs, index_o and busy_o.
- R2: When inhibit_n_i is high and busy_i is low at an edge, the holding register takes angle_i on that edge. The new value appears on any enabled half of data_o right after the edge.
- R3: When inhibit_n_i is low at an edge, the holding register keeps its value. The quadrature, index and busy outputs still follow the live angle_i.
- R4: When busy_i is high at an edge, the holding register keeps its value, even if inhibit_n_i is high.
- R5: oe_hi_o equals the inverse of en_hi_n_i as sampled OE_LAT edges earlier (default 2). While oe_hi_o is low, data_o[15:8] reads 0. While it is high, that half shows bits 15..8 of the holding register, with bit 15 as the MSB.
- R6: oe_lo_o follows en_lo_n_i in the same way as R5 when encoder mode is off. data_o[7:0] is gated by oe_lo_o.
- R7: res_sel_i selects the resolution: 0 = 10 bits, 1 = 12, 2 = 14, 3 = 16. The 16 − N low bits of data_o read 0, where N is the selected width in bits. This masking uses the current res_sel_i.
- R8: If enc_mode_i is high at an edge, oe_lo_o is high after that edge, whatever en_lo_n_i is.
- R9: In encoder mode, let L = 6 − 2·res_sel_i. After each edge, quad_a_o = angle_i[L+1] and quad_b_o = angle_i[L] XOR angle_i[L+1], taken from the angle sampled at that edge.
- R10: In encoder mode, index_o and busy_o are both 1 after an edge exactly when bits 15..L of the sampled angle_i are all zero.
- R11: With encoder mode off, busy_o is busy_i delayed by one edge, and quad_a_o, quad_b_o and index_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| angle_i | input | 16 | Live tracked angle, bit 15 is the MSB |
| busy_i | input | 1 | Counter-busy strobe, high while the count changes |
| inhibit_n_i | input | 1 | Active-low freeze of the holding register |
| en_hi_n_i | input | 1 | Active-low read enable, upper half |
| en_lo_n_i | input | 1 | Active-low read enable, lower half |
| res_sel_i | input | 2 | Resolution code (0..3 → 10..16 bits) |
| enc_mode_i | input | 1 | Encoder emulation select |
| data_o | output | 16 | Held, masked angle gated by half enables |
| oe_hi_o | output | 1 | Drive enable for data_o[15:8] |
| oe_lo_o | output | 1 | Drive enable for data_o[7:0] |
| quad_a_o | output | 1 | Quadrature channel A |
| quad_b_o | output | 1 | Quadrature channel B |
| index_o | output | 1 | Zero-position index |
| busy_o | output | 1 | Delayed busy, or the index in encoder mode |

## Verification
The channel check assumes that, while encoder mode is on and the resolution does not change, the live angle moves by at most one step of the selected resolution per clock. Under that condition A and B never toggle on the same clock. The stimulus keeps to this rule: in encoder mode it steps the angle by ±1 LSB, wrapping through zero. It changes the resolution or makes large jumps only with encoder mode off. The enable-latency checks count consecutive enable samples taken after reset. The stimulus therefore holds each enable level for several clocks before and after each transition.

// File: rtl/angle_readout_pkg.sv
// Shared types and helpers for the angle readout port.
// Assumes the angle word is at least 10 bits wide.
package angle_readout_pkg;

    typedef enum logic [1:0] {
        RES_10 = 2'd0,
        RES_12 = 2'd1,
        RES_14 = 2'd2,
        RES_16 = 2'd3
    } res_e;

    // Position of the lowest active bit for a resolution code.
    function automatic int unsigned lsb_index(input res_e r, input int unsigned width);
        return width - 10 - 2 * int'(r);
    endfunction

endpackage

// File: rtl/angle_res_mask.sv
// Clears the angle bits that lie below the selected resolution.
// Purely combinational; assumes WIDTH >= 10.
module angle_res_mask
    import angle_readout_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] raw_i,
    input  res_e             res_i,
    output logic [WIDTH-1:0] masked_o
);
    int unsigned lsb;

    // Lowest live bit position for the current resolution.
    always_comb lsb = lsb_index(res_i, WIDTH);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        assign masked_o[gi] = raw_i[gi] & (gi >= lsb);
    end

endmodule

// File: rtl/angle_hold_reg.sv
// Transparent-style holding register for the angle word.
// Follows the counter while not inhibited and outside busy strobes.
// Assumes busy_i covers every clock on which the count is unsettled.
module angle_hold_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] angle_i,
    input  logic             busy_i,
    input  logic             inhibit_n_i,
    output logic [WIDTH-1:0] held_o
);
    logic [WIDTH-1:0] held_q;

    // Capture the live angle only when reading is not frozen and the count is settled.
    always_ff @(posedge clk) begin
        if (!rst_n)                     held_q <= '0;
        else if (inhibit_n_i && !busy_i) held_q <= angle_i;
    end

    assign held_o = held_q;

endmodule

// File: rtl/oe_delay_line.sv
// Delays an output-enable request by a fixed number of clocks, which models
// the bus turn-on and turn-off times. Assumes LAT >= 1.
module oe_delay_line #(
    parameter int unsigned LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic oe_o
);
    if (LAT == 1) begin : g_single
        logic stage_q;
        // Single stage register.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= req_i;
        end
        assign oe_o = stage_q;
    end else begin : g_chain
        logic [LAT-1:0] sh_q;
        // Shift the request through LAT stages.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[LAT-2:0], req_i};
        end
        assign oe_o = sh_q[LAT-1];
    end

endmodule

// File: rtl/quad_emulator.sv
// Produces quadrature A/B and a zero index from the live angle. In encoder
// mode the busy output carries the index; otherwise it is a delayed busy.
// Assumes live_masked_i has already had the sub-resolution bits cleared.
module quad_emulator
    import angle_readout_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_i,
    input  res_e             res_i,
    input  logic [WIDTH-1:0] angle_i,
    input  logic [WIDTH-1:0] live_masked_i,
    input  logic             busy_i,
    output logic             enc_o,
    output logic             quad_a_o,
    output logic             quad_b_o,
    output logic             index_o,
    output logic             busy_o
);
    localparam int unsigned IDX_W = $clog2(WIDTH);

    logic [IDX_W-1:0] lsb_idx;
    logic [IDX_W-1:0] next_idx;
    logic             bit_lo;
    logic             bit_up;
    logic             at_zero;
    logic             enc_q, a_q, b_q, idx_q, busy_q;

    // Select the two lowest live bits and detect the zero position.
    always_comb begin
        lsb_idx  = IDX_W'(lsb_index(res_i, WIDTH));
        next_idx = lsb_idx + IDX_W'(1);
        bit_lo   = angle_i[lsb_idx];
        bit_up   = angle_i[next_idx];
        at_zero  = (live_masked_i == '0);
    end

    // Register the encoder outputs and the shared busy/index pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_q  <= 1'b0;
            a_q    <= 1'b0;
            b_q    <= 1'b0;
            idx_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            enc_q  <= enc_i;
            a_q    <= enc_i & bit_up;
            b_q    <= enc_i & (bit_lo ^ bit_up);
            idx_q  <= enc_i & at_zero;
            busy_q <= enc_i ? at_zero : busy_i;
        end
    end

    assign enc_o    = enc_q;
    assign quad_a_o = a_q;
    assign quad_b_o = b_q;
    assign index_o  = idx_q;
    assign busy_o   = busy_q;

endmodule

// File: rtl/angle_readout_port.sv
// Top of the angle readout port. Holds the tracked angle for the host,
// masks it to the selected resolution, gates each half of the word with a
// delayed output enable, and emulates an incremental encoder on request.
// Assumes ANG_W is 16 so that the word splits into two byte halves.
module angle_readout_port
    import angle_readout_pkg::*;
#(
    parameter int unsigned ANG_W  = 16,
    parameter int unsigned OE_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ANG_W-1:0] angle_i,
    input  logic             busy_i,
    input  logic             inhibit_n_i,
    input  logic             en_hi_n_i,
    input  logic             en_lo_n_i,
    input  logic [1:0]       res_sel_i,
    input  logic             enc_mode_i,
    output logic [ANG_W-1:0] data_o,
    output logic             oe_hi_o,
    output logic             oe_lo_o,
    output logic             quad_a_o,
    output logic             quad_b_o,
    output logic             index_o,
    output logic             busy_o
);
    localparam int unsigned HALF_W = ANG_W / 2;
    localparam int unsigned LANES  = 2;

    res_e             res;
    logic [ANG_W-1:0] held_q;
    logic [ANG_W-1:0] held_masked;
    logic [ANG_W-1:0] live_masked;
    logic [LANES-1:0] req_vec;
    logic [LANES-1:0] pipe_oe;
    logic [LANES-1:0] lane_oe;
    logic             enc_q;

    assign res     = res_e'(res_sel_i);
    assign req_vec = {~en_hi_n_i, ~en_lo_n_i};

    angle_hold_reg #(.WIDTH(ANG_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .angle_i     (angle_i),
        .busy_i      (busy_i),
        .inhibit_n_i (inhibit_n_i),
        .held_o      (held_q)
    );

    angle_res_mask #(.WIDTH(ANG_W)) u_mask_held (
        .raw_i    (held_q),
        .res_i    (res),
        .masked_o (held_masked)
    );

    angle_res_mask #(.WIDTH(ANG_W)) u_mask_live (
        .raw_i    (angle_i),
        .res_i    (res),
        .masked_o (live_masked)
    );

    quad_emulator #(.WIDTH(ANG_W)) u_quad (
        .clk           (clk),
        .rst_n         (rst_n),
        .enc_i         (enc_mode_i),
        .res_i         (res),
        .angle_i       (angle_i),
        .live_masked_i (live_masked),
        .busy_i        (busy_i),
        .enc_o         (enc_q),
        .quad_a_o      (quad_a_o),
        .quad_b_o      (quad_b_o),
        .index_o       (index_o),
        .busy_o        (busy_o)
    );

    // One enable delay line and data gate per half of the word; lane 0 is the lower half.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        oe_delay_line #(.LAT(OE_LAT)) u_oe (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req_vec[ln]),
            .oe_o  (pipe_oe[ln])
        );
        if (ln == 0) begin : g_lower
            assign lane_oe[ln] = pipe_oe[ln] | enc_q;
        end else begin : g_upper
            assign lane_oe[ln] = pipe_oe[ln];
        end
        assign data_o[ln*HALF_W +: HALF_W] =
            lane_oe[ln] ? held_masked[ln*HALF_W +: HALF_W] : '0;
    end

    assign oe_lo_o = lane_oe[0];
    assign oe_hi_o = lane_oe[1];

endmodule

// File: rtl/angle_readout_chk.sv
// Property checker for angle_readout_port, attached with bind.
// Assumes that in encoder mode the angle moves at most one live LSB per clock.
module angle_readout_chk #(
    parameter int unsigned ANG_W  = 16,
    parameter int unsigned OE_LAT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ANG_W-1:0] angle_i,
    input logic             busy_i,
    input logic             inhibit_n_i,
    input logic             en_hi_n_i,
    input logic             en_lo_n_i,
    input logic [1:0]       res_sel_i,
    input logic             enc_mode_i,
    input logic [ANG_W-1:0] held_i,
    input logic             oe_hi_o,
    input logic             oe_lo_o,
    input logic             quad_a_o,
    input logic             quad_b_o,
    input logic             index_o,
    input logic             busy_o
);
    localparam int unsigned CW  = $clog2(OE_LAT + 1);
    localparam logic [CW-1:0] SAT = CW'(OE_LAT);

    logic [CW-1:0] hi_off_q, hi_on_q, lo_off_q, lo_on_q;

    // Saturating run counters of consecutive enable levels since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_off_q <= '0; hi_on_q <= '0; lo_off_q <= '0; lo_on_q <= '0;
        end else begin
            hi_off_q <= !en_hi_n_i ? '0 : (hi_off_q == SAT ? SAT : hi_off_q + 1'b1);
            hi_on_q  <=  en_hi_n_i ? '0 : (hi_on_q  == SAT ? SAT : hi_on_q  + 1'b1);
            lo_off_q <= !en_lo_n_i ? '0 : (lo_off_q == SAT ? SAT : lo_off_q + 1'b1);
            lo_on_q  <=  en_lo_n_i ? '0 : (lo_on_q  == SAT ? SAT : lo_on_q  + 1'b1);
        end
    end

    a_r3_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n_i |=> $stable(held_i));

    a_r4_busy_skips: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(held_i));

    a_r5_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_off_q == SAT) |-> !oe_hi_o);

    a_r5_hi_on: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_on_q == SAT) |-> oe_hi_o);

    a_r6_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_off_q == SAT) && !$past(enc_mode_i)) |-> !oe_lo_o);

    a_r6_lo_on: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_on_q == SAT) |-> oe_lo_o);

    a_r8_lo_forced: assert property (@(posedge clk) disable iff (!rst_n)
        enc_mode_i |=> oe_lo_o);

    a_r9_one_channel_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enc_mode_i) && enc_mode_i && $stable(res_sel_i))
        |=> !(!$stable(quad_a_o) && !$stable(quad_b_o)));

    a_r10_index_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        enc_mode_i |=> (busy_o == index_o));

    a_r11_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_mode_i |=> (!quad_a_o && !quad_b_o && !index_o));

endmodule

bind angle_readout_port angle_readout_chk #(.ANG_W(ANG_W), .OE_LAT(OE_LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .angle_i     (angle_i),
    .busy_i      (busy_i),
    .inhibit_n_i (inhibit_n_i),
    .en_hi_n_i   (en_hi_n_i),
    .en_lo_n_i   (en_lo_n_i),
    .res_sel_i   (res_sel_i),
    .enc_mode_i  (enc_mode_i),
    .held_i      (held_q),
    .oe_hi_o     (oe_hi_o),
    .oe_lo_o     (oe_lo_o),
    .quad_a_o    (quad_a_o),
    .quad_b_o    (quad_b_o),
    .index_o     (index_o),
    .busy_o      (busy_o)
);

// File: tb/tb_angle_readout_port.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares after each edge.
module tb_angle_readout_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] angle_i;
    logic        busy_i, inhibit_n_i, en_hi_n_i, en_lo_n_i, enc_mode_i;
    logic [1:0]  res_sel_i;
    logic [15:0] data_o;
    logic        oe_hi_o, oe_lo_o, quad_a_o, quad_b_o, index_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] data;
        logic        oe_hi, oe_lo, qa, qb, idx, bsy;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] m_held = '0;
    logic        prev_hi = 1'b0;
    logic        prev_lo = 1'b0;

    always #10 clk = ~clk;

    angle_readout_port dut (
        .clk(clk), .rst_n(rst_n), .angle_i(angle_i), .busy_i(busy_i),
        .inhibit_n_i(inhibit_n_i), .en_hi_n_i(en_hi_n_i), .en_lo_n_i(en_lo_n_i),
        .res_sel_i(res_sel_i), .enc_mode_i(enc_mode_i), .data_o(data_o),
        .oe_hi_o(oe_hi_o), .oe_lo_o(oe_lo_o), .quad_a_o(quad_a_o),
        .quad_b_o(quad_b_o), .index_o(index_o), .busy_o(busy_o)
    );

    function automatic logic [15:0] keep_bits(input logic [15:0] v, input logic [1:0] r);
        int unsigned drop = 6 - 2 * int'(r);
        return v & ~((16'd1 << drop) - 16'd1);
    endfunction

    task automatic drive(input logic [15:0] ang, input logic bsy, input logic inh_n,
                         input logic enh_n, input logic enl_n, input logic [1:0] res,
                         input logic enc, input string tag);
        exp_t        e;
        logic [15:0] mk;
        int unsigned l;
        @(negedge clk);
        angle_i = ang; busy_i = bsy; inhibit_n_i = inh_n;
        en_hi_n_i = enh_n; en_lo_n_i = enl_n; res_sel_i = res; enc_mode_i = enc;
        if (inh_n && !bsy) m_held = ang;
        e.oe_hi = prev_hi;
        e.oe_lo = enc | prev_lo;
        prev_hi = !enh_n;
        prev_lo = !enl_n;
        mk = keep_bits(m_held, res);
        e.data = {e.oe_hi ? mk[15:8] : 8'h00, e.oe_lo ? mk[7:0] : 8'h00};
        l = 6 - 2 * int'(res);
        e.qa  = enc & ang[l+1];
        e.qb  = enc & (ang[l] ^ ang[l+1]);
        e.idx = enc & (keep_bits(ang, res) == 16'h0000);
        e.bsy = enc ? (keep_bits(ang, res) == 16'h0000) : bsy;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares queued expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (data_o !== e.data || oe_hi_o !== e.oe_hi || oe_lo_o !== e.oe_lo ||
                    quad_a_o !== e.qa || quad_b_o !== e.qb || index_o !== e.idx ||
                    busy_o !== e.bsy) begin
                    errors++;
                    $display("FAIL %s: got data=%h oeh=%b oel=%b a=%b b=%b idx=%b busy=%b, expected data=%h oeh=%b oel=%b a=%b b=%b idx=%b busy=%b",
                             e.tag, data_o, oe_hi_o, oe_lo_o, quad_a_o, quad_b_o, index_o, busy_o,
                             e.data, e.oe_hi, e.oe_lo, e.qa, e.qb, e.idx, e.bsy);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with enables and encoder mode requested
        rst_n = 1'b0; angle_i = 16'hBEEF; busy_i = 1'b1; inhibit_n_i = 1'b1;
        en_hi_n_i = 1'b0; en_lo_n_i = 1'b0; res_sel_i = 2'd3; enc_mode_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({data_o, oe_hi_o, oe_lo_o, quad_a_o, quad_b_o, index_o, busy_o} !== 22'h0) begin
            errors++;
            $display("FAIL R1: got data=%h oeh=%b oel=%b a=%b b=%b idx=%b busy=%b, expected all 0",
                     data_o, oe_hi_o, oe_lo_o, quad_a_o, quad_b_o, index_o, busy_o);
        end
        @(negedge clk);
        rst_n = 1'b1; angle_i = 16'h0000; busy_i = 1'b0;
        en_hi_n_i = 1'b1; en_lo_n_i = 1'b1; enc_mode_i = 1'b0;

        // R5 R6: enables off, then on after the latency; R2 transparent follow
        drive(16'h1234, 0, 1, 1, 1, 3, 0, "R5");
        drive(16'h1234, 0, 1, 0, 0, 3, 0, "R6");
        drive(16'hA5C3, 0, 1, 0, 0, 3, 0, "R5");
        drive(16'h5A3C, 0, 1, 0, 0, 3, 0, "R2");
        drive(16'hFFFF, 0, 1, 0, 0, 3, 0, "R2");
        // R7: resolution masking
        drive(16'hFFFF, 0, 1, 0, 0, 0, 0, "R7");
        drive(16'hFFFF, 0, 1, 0, 0, 1, 0, "R7");
        drive(16'hFFFF, 0, 1, 0, 0, 2, 0, "R7");
        // R4: busy blocks capture; R11 busy delayed
        drive(16'h0F0F, 1, 1, 0, 0, 3, 0, "R4");
        drive(16'h0F0F, 1, 1, 0, 0, 3, 0, "R11");
        drive(16'h0F0F, 0, 1, 0, 0, 3, 0, "R2");
        // R3: inhibit freezes while angle moves
        drive(16'h7777, 0, 0, 0, 0, 3, 0, "R3");
        drive(16'h8888, 0, 0, 0, 0, 3, 0, "R3");
        drive(16'h9999, 0, 0, 0, 0, 3, 0, "R3");
        drive(16'h9999, 0, 1, 0, 0, 3, 0, "R3");
        // R5 R6: releasing one enable at a time
        drive(16'h4321, 0, 1, 1, 0, 3, 0, "R5");
        drive(16'h4321, 0, 1, 1, 0, 3, 0, "R5");
        drive(16'h4321, 0, 1, 1, 1, 3, 0, "R6");
        drive(16'h4321, 0, 1, 1, 1, 3, 0, "R6");
        drive(16'h0003, 0, 1, 1, 1, 3, 0, "R11");
        // R8 R9 R10: encoder mode at 16 bits, unit steps through zero
        drive(16'h0003, 0, 1, 1, 1, 3, 1, "R8");
        drive(16'h0002, 0, 1, 1, 1, 3, 1, "R9");
        drive(16'h0001, 0, 1, 1, 1, 3, 1, "R9");
        drive(16'h0000, 0, 1, 1, 1, 3, 1, "R10");
        drive(16'hFFFF, 0, 1, 1, 1, 3, 1, "R9");
        drive(16'hFFFE, 0, 0, 0, 1, 3, 1, "R3");
        drive(16'hFFFF, 0, 0, 0, 1, 3, 1, "R3");
        drive(16'h0000, 0, 0, 0, 1, 3, 1, "R10");
        drive(16'h0001, 1, 1, 0, 1, 3, 1, "R10");
        // leave encoder mode, change resolution with encoder off
        drive(16'h0030, 0, 1, 1, 1, 1, 0, "R11");
        drive(16'h0030, 0, 1, 1, 1, 1, 0, "R6");
        // R9 R10: encoder mode at 12 bits, steps of 16
        drive(16'h0030, 0, 1, 1, 1, 1, 1, "R8");
        drive(16'h0020, 0, 1, 1, 1, 1, 1, "R9");
        drive(16'h001F, 0, 1, 1, 1, 1, 1, "R9");
        drive(16'h000F, 0, 1, 1, 1, 1, 1, "R10");
        drive(16'hFFF0, 0, 1, 1, 1, 1, 1, "R9");
        drive(16'hFFE0, 0, 1, 1, 1, 1, 1, "R9");
        drive(16'hFFE0, 0, 1, 1, 1, 1, 0, "R11");
        drive(16'hFFE0, 0, 1, 1, 1, 1, 0, "R6");

        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule